// File: doc/BRIEF.md
# Three-State Trace Sequencer

This block is a small state machine used inside debug and trace logic. It has three states (1, 2 and 3) and moves between them in response to external event lines. Each of the six directed moves between two distinct states has its own programmable selector. The selector names one bit of a 128-bit event vector, and that bit triggers the move. The current state is driven out on a port so that neighbouring trace logic can qualify its filters with it.

A debugger reaches the block through a simple word-addressed register port. The selectors are loaded while a programming-mode input is high, and the sequencer is frozen during that time. When programming mode ends, the sequencer normally restarts from state 1. A configuration-extension input widens the access rules. With it set, the debugger can read back the selectors and write the state register, and a state written after the last selector write survives the end of programming mode.

Top module: `trace_seq3`

## Requirements
- R1: A synchronous active-high reset sets the state to 1, every selector to 127 and clears the pinned-state flag. The state output never shows 0.
- R2: Selectors sit at byte addresses 0x180 + 4*k for k = 0..5, in the order 1→2, 2→1, 2→3, 3→1, 3→2, 1→3. The state register is at 0x19C, with the state in bits [1:0] coded as 1, 2 or 3. Address 0x198 is reserved: it reads 0 and ignores writes.
- R3: Outside programming mode, if exactly one of the current state's two outgoing selected event bits is 1 at a rising edge, the state output shows that move's destination after that edge. Events that belong to moves from other states have no effect.
- R4: If both outgoing moves of the current state fire at the same edge, the state does not change.
- R5: A selector holding 127 never fires, even when event bit 127 is 1.
- R6: While programming mode is 1, events do not change the state.
- R7: Selector writes (bits [6:0]) are always accepted. With the extension input at 1, a selector reads back in bits [6:0]. With it at 0, a selector reads as 0.
- R8: The state register always reads the current state. A write to it takes effect only when the extension input is 1, and a write of 0 is ignored.
- R9: When programming mode falls from 1 to 0, the state becomes 1. The exception is when the extension input is 1 and the state register was written after the most recent selector write; then the state is kept.
- R10: A state-register write that is accepted in the same cycle as a firing move sets the state to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode | input | 1 | Programming mode; freezes the sequencer while 1 |
| ext_mode | input | 1 | Configuration-extension flag enabling readback and state writes |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re, 0 otherwise |
| ev_in | input | 128 | Event vector sampled every clock |
| state_o | output | 2 | Current sequencer state (1, 2 or 3) |

## Verification
Two situations can land on the same clock edge. In the first, both moves leaving the current state fire together. The bench raises both selected event bits in one cycle and expects the state to hold. In the second, a debugger write to the state register meets a firing move. The bench writes state 2 while raising the 3→1 event bit and expects the written value, not the move's destination, after the edge.

// File: rtl/trace_seq3_pkg.sv
`timescale 1ns/1ps
package trace_seq3_pkg;

    typedef enum logic [1:0] {
        SQ_NONE = 2'd0,
        SQ_S1   = 2'd1,
        SQ_S2   = 2'd2,
        SQ_S3   = 2'd3
    } sq_state_e;

    localparam int TRN_CNT   = 6;
    localparam int REG_BASE  = 32'h60;
    localparam int REG_STATE = 32'h67;

    typedef struct packed {
        sq_state_e src;
        sq_state_e dst;
    } trn_arc_t;

    typedef struct packed {
        logic      wr;
        sq_state_e val;
    } st_req_t;

    // Source and destination of each selector slot, by slot index
    function automatic trn_arc_t arc_of(input int idx);
        trn_arc_t a;
        case (idx)
            0:       a = '{src: SQ_S1, dst: SQ_S2};
            1:       a = '{src: SQ_S2, dst: SQ_S1};
            2:       a = '{src: SQ_S2, dst: SQ_S3};
            3:       a = '{src: SQ_S3, dst: SQ_S1};
            4:       a = '{src: SQ_S3, dst: SQ_S2};
            default: a = '{src: SQ_S1, dst: SQ_S3};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/trace_seq3_regs.sv
`timescale 1ns/1ps
module trace_seq3_regs
    import trace_seq3_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 7,
    parameter int NEVER_SEL = 127
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ext_mode,
    input  logic                            bus_we,
    input  logic                            bus_re,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  sq_state_e                       cur_state,
    output logic [TRN_CNT-1:0][SEL_W-1:0]   sel_bank,
    output st_req_t                         st_req,
    output logic                            ev_wr,
    output logic [DATA_W-1:0]               bus_rdata
);
    localparam int RN_W = ADDR_W - 2;

    logic [RN_W-1:0]    reg_num;
    logic [TRN_CNT-1:0] sel_hit;
    logic               st_hit;
    logic               unused_bits;

    assign reg_num     = bus_addr[ADDR_W-1:2];
    assign st_hit      = (reg_num == RN_W'(REG_STATE));
    assign unused_bits = ^{bus_wdata[DATA_W-1:SEL_W], bus_addr[1:0]};

    for (genvar i = 0; i < TRN_CNT; i++) begin : g_sel
        assign sel_hit[i] = (reg_num == RN_W'(REG_BASE + i));
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_bank[i] <= SEL_W'(NEVER_SEL);
            end else if (bus_we && sel_hit[i]) begin
                sel_bank[i] <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    assign ev_wr      = bus_we && (|sel_hit);
    assign st_req.wr  = bus_we && st_hit && ext_mode && (bus_wdata[1:0] != 2'd0);
    assign st_req.val = sq_state_e'(bus_wdata[1:0]);

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (st_hit) begin
                bus_rdata = {{(DATA_W-2){1'b0}}, cur_state};
            end else if (ext_mode) begin
                for (int i = 0; i < TRN_CNT; i++) begin
                    if (sel_hit[i]) begin
                        bus_rdata = DATA_W'(sel_bank[i]);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/trace_seq3_next.sv
`timescale 1ns/1ps
module trace_seq3_next
    import trace_seq3_pkg::*;
#(
    parameter int EV_W      = 128,
    parameter int SEL_W     = 7,
    parameter int NEVER_SEL = 127
) (
    input  sq_state_e                      cur_state,
    input  logic [TRN_CNT-1:0][SEL_W-1:0]  sel_bank,
    input  logic [EV_W-1:0]                ev_in,
    output sq_state_e                      nxt_state
);
    logic [TRN_CNT-1:0] fire;

    for (genvar i = 0; i < TRN_CNT; i++) begin : g_fire
        assign fire[i] = (sel_bank[i] != SEL_W'(NEVER_SEL)) && ev_in[sel_bank[i]];
    end

    logic [2:0] hit_cnt;
    sq_state_e  hit_dst;

    always_comb begin
        hit_cnt = '0;
        hit_dst = cur_state;
        for (int i = 0; i < TRN_CNT; i++) begin
            if (fire[i] && (arc_of(i).src == cur_state)) begin
                hit_cnt = hit_cnt + 3'd1;
                hit_dst = arc_of(i).dst;
            end
        end
        nxt_state = (hit_cnt == 3'd1) ? hit_dst : cur_state;
    end

endmodule

// File: rtl/trace_seq3.sv
`timescale 1ns/1ps
module trace_seq3
    import trace_seq3_pkg::*;
#(
    parameter int EV_W   = 128,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_mode,
    input  logic              ext_mode,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EV_W-1:0]   ev_in,
    output logic [1:0]        state_o
);
    localparam int SEL_W     = $clog2(EV_W);
    localparam int NEVER_SEL = EV_W - 1;

    sq_state_e                     state_q;
    sq_state_e                     nxt_state;
    logic                          prog_q;
    logic                          pinned_q;
    logic                          ev_wr;
    st_req_t                       st_req;
    logic [TRN_CNT-1:0][SEL_W-1:0] sel_bank;

    trace_seq3_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .NEVER_SEL(NEVER_SEL)
    ) u_regs (
        .clk(clk), .rst(rst), .ext_mode(ext_mode),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cur_state(state_q), .sel_bank(sel_bank),
        .st_req(st_req), .ev_wr(ev_wr), .bus_rdata(bus_rdata)
    );

    trace_seq3_next #(
        .EV_W(EV_W), .SEL_W(SEL_W), .NEVER_SEL(NEVER_SEL)
    ) u_next (
        .cur_state(state_q), .sel_bank(sel_bank), .ev_in(ev_in),
        .nxt_state(nxt_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_S1;
            prog_q   <= 1'b0;
            pinned_q <= 1'b0;
        end else begin
            prog_q <= prog_mode;
            if (st_req.wr) begin
                pinned_q <= 1'b1;
            end else if (ev_wr) begin
                pinned_q <= 1'b0;
            end
            if (st_req.wr) begin
                state_q <= st_req.val;
            end else if (prog_q && !prog_mode) begin
                state_q <= (ext_mode && pinned_q) ? state_q : SQ_S1;
            end else if (!prog_mode) begin
                state_q <= nxt_state;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/trace_seq3_chk.sv
`timescale 1ns/1ps
module trace_seq3_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_mode,
    input logic              ext_mode,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        state_o
);
    localparam int RN_W = ADDR_W - 2;

    logic [RN_W-1:0] rn;
    logic            st_wr;
    logic            sel_rd;
    logic            unused_chk;

    assign rn         = bus_addr[ADDR_W-1:2];
    assign st_wr      = bus_we && (rn == RN_W'(32'h67));
    assign sel_rd     = bus_re && (rn >= RN_W'(32'h60)) && (rn <= RN_W'(32'h65));
    assign unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:2]};

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'd0);                                                        // R1

    AST_FROZEN_IN_PROG: assert property (@(posedge clk) disable iff (rst)
        (prog_mode && !(st_wr && ext_mode)) |=> $stable(state_o));               // R6

    AST_EXIT_TO_ONE: assert property (@(posedge clk) disable iff (rst)
        ($fell(prog_mode) && !ext_mode) |=> (state_o == 2'd1));                  // R9

    AST_SEL_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && sel_rd) |-> (bus_rdata == '0));                            // R7

    AST_STATE_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && st_wr && (bus_wdata[1:0] != 2'd0))
        |=> (state_o == $past(bus_wdata[1:0])));                                 // R10

endmodule

bind trace_seq3 trace_seq3_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .ext_mode(ext_mode),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .state_o(state_o)
);

// File: tb/trace_seq3_test.sv
`timescale 1ns/1ps
module trace_seq3_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         prog_mode = 1'b0;
    logic         ext_mode = 1'b0;
    logic         bus_we = 1'b0;
    logic         bus_re = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] ev_in = '0;
    logic [1:0]   state_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    trace_seq3 uut (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .ext_mode(ext_mode),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_in(ev_in),
        .state_o(state_o)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_rd ? bus_rdata : {30'd0, state_o};
            total++;
            if (it.due != cyc || act !== it.exp) begin
                bad++;
                $display("FAIL %s: %s actual=0x%0h expected=0x%0h",
                         it.req, it.is_rd ? "rdata" : "state", act, it.exp);
            end
        end
    end

    // Driver tasks: start and end 2 ns after a rising edge
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic expect_state(input logic [1:0] v, input string req);
        item_t it;
        it.due = cyc; it.is_rd = 1'b0; it.exp = {30'd0, v}; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
        item_t it;
        bus_re = 1'b1; bus_addr = a;
        it.due = cyc; it.is_rd = 1'b1; it.exp = exp; it.req = req;
        sb.push_back(it);
        tick();
        bus_re = 1'b0;
    endtask

    task automatic pulse(input int a, input int b);
        ev_in = '0;
        if (a >= 0) ev_in[a] = 1'b1;
        if (b >= 0) ev_in[b] = 1'b1;
        tick();
        ev_in = '0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        expect_state(2'd1, "R1");
        ext_mode = 1'b1;
        rd_check(12'h19C, 32'd1, "R1");
        rd_check(12'h180, 32'd127, "R1");

        // program selectors in order 1-2,2-1,2-3,3-1,3-2,1-3 -> events 5..10
        prog_mode = 1'b1;
        wr(12'h180, 32'd5);
        wr(12'h184, 32'd6);
        wr(12'h188, 32'd7);
        wr(12'h18C, 32'd8);
        wr(12'h190, 32'd9);
        wr(12'h194, 32'hFFFF_FF8A);      // upper bits dropped -> 10
        wr(12'h198, 32'd3);              // reserved
        rd_check(12'h188, 32'd7, "R2");
        rd_check(12'h194, 32'd10, "R7");
        rd_check(12'h198, 32'd0, "R2");
        ext_mode = 1'b0;
        rd_check(12'h180, 32'd0, "R7");
        ext_mode = 1'b1;

        pulse(5, -1);  expect_state(2'd1, "R6");
        prog_mode = 1'b0;
        tick();        expect_state(2'd1, "R9");

        pulse(5, -1);  expect_state(2'd2, "R3");
        pulse(10, -1); expect_state(2'd2, "R3");   // 1->3 event while in 2
        pulse(7, -1);  expect_state(2'd3, "R3");
        pulse(9, -1);  expect_state(2'd2, "R3");
        pulse(6, -1);  expect_state(2'd1, "R3");
        pulse(10, -1); expect_state(2'd3, "R3");
        pulse(8, -1);  expect_state(2'd1, "R3");
        pulse(5, 10);  expect_state(2'd1, "R4");
        pulse(6, 9);   expect_state(2'd1, "R3");

        wr(12'h180, 32'd127);
        pulse(127, -1); expect_state(2'd1, "R5");
        pulse(5, 127);  expect_state(2'd1, "R5");
        wr(12'h180, 32'd5);

        ext_mode = 1'b0;
        wr(12'h19C, 32'd3); expect_state(2'd1, "R8");
        ext_mode = 1'b1;
        wr(12'h19C, 32'd0); expect_state(2'd1, "R8");
        wr(12'h19C, 32'd3); expect_state(2'd3, "R8");
        rd_check(12'h19C, 32'd3, "R8");

        // write collides with firing 3->1 move
        ev_in = '0; ev_in[8] = 1'b1;
        wr(12'h19C, 32'd2);
        ev_in = '0;
        expect_state(2'd2, "R10");

        // pinned state survives programming exit
        wr(12'h19C, 32'd3);
        prog_mode = 1'b1; tick();
        prog_mode = 1'b0; tick(); expect_state(2'd3, "R9");
        // selector write after state write unpins
        prog_mode = 1'b1; wr(12'h184, 32'd6);
        prog_mode = 1'b0; tick(); expect_state(2'd1, "R9");
        // pinned but extension off -> back to 1
        wr(12'h19C, 32'd2); expect_state(2'd2, "R9");
        ext_mode = 1'b0;
        prog_mode = 1'b1; tick();
        prog_mode = 1'b0; tick(); expect_state(2'd1, "R9");

        tick(); tick();
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule